// File: doc/BRIEF.md
# SCSI Initiator Host Register Front End

This block is the host-facing register file of a parallel SCSI initiator controller. A host reaches eight byte-wide locations through a three-bit offset, a write strobe and a read strobe. Behind those offsets sit the byte the controller may drive onto the SCSI data lines, the initiator command byte, the mode byte and the target command byte. Two read-only status words are built from the SCSI bus lines as sampled in the current cycle. One is the raw control/status byte. The other packs a phase-match indication, a request-for-data bit, a lost-busy error and the latched event flags.

Two write offsets serve as strobes that start a DMA transfer: a send, or an initiator-side receive. The block presents the selected transfer direction and a combined transfer-active signal to a separate transfer sequencer. That sequencer reports back with pulses for end of transfer, last byte sent and parity error. The block latches these as flags and raises its interrupt output from them. Reading offset 7 clears the interrupt and parity flags. Writing the mode byte with its DMA bit clear stops a transfer.

Top module: `scsi_host_regs`

## Requirements
- R1: While reset is asserted, and until the two-stage reset release has completed, all stored bytes read as 0x00, the transfer direction is idle (0), transfer-active is 0 and the interrupt output is 0.
- R2: A read of offset 0 returns the stored output byte when bit 0 (drive-data) of the initiator command byte is 1, and returns the live bus data otherwise.
- R3: Offsets 0 to 3 are written with a write strobe. Offsets 1 and 2 read back the full byte written. Offset 3 reads back the low 4 bits written, bit 7 is the last-byte-sent flag, and bits 6 to 4 read 0.
- R4: A read of offset 4 returns the sampled bus control byte unchanged. Its bit positions are BSY=6, REQ=5, MSG=4, C/D=3, I/O=2.
- R5: In a read of offset 5, bit 3 is 1 when target command bits {2,1,0} equal the bus {MSG,C/D,I/O}. Bit 0 follows the bus ACK input. Bit 6 is 1 only when REQ is 1 and mode bit 1 (DMA enable) is 1.
- R6: In a read of offset 5, bit 2 is 1 when BSY is 0 and mode bit 2 (busy monitor) is 1. Bit 4 shows the interrupt flag, bit 5 the parity flag and bit 7 the end-of-transfer flag.
- R7: A write to offset 5 selects send (direction 1), and a write to offset 7 selects initiator receive (direction 2), regardless of the data byte. Transfer-active equals mode bit 1 AND a non-idle direction. It changes in the cycle after the write.
- R8: A write of the mode byte with bit 1 clear sets the direction to idle and clears the last-byte-sent and end-of-transfer flags. This clear wins over a same-cycle set pulse.
- R9: A read strobe at offset 7 clears the interrupt and parity flags. A set pulse in the same cycle wins over the clear.
- R10: Reads of offsets 6 and 7 return 0xFF.
- R11: An end-of-transfer pulse sets the end-of-transfer flag, and also sets the interrupt flag when mode bit 3 (end interrupt enable) is 1. A last-byte pulse sets target command bit 7. The interrupt output equals the interrupt flag.
- R12: Writes to offsets 4 and 6 change no stored byte and no transfer direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, used for the side effect of offset 7 |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for the current offset, combinational |
| bus_data_in | input | DATA_W | Sampled SCSI data lines |
| bus_ctl_in | input | DATA_W | Sampled SCSI control/status lines |
| bus_ack_in | input | 1 | Sampled SCSI ACK line |
| par_err_in | input | 1 | Parity error pulse from the sequencer |
| eop_in | input | 1 | End-of-transfer pulse from the sequencer |
| lbs_in | input | 1 | Last-byte-sent pulse from the sequencer |
| odr_out | output | DATA_W | Stored output byte, to the bus drivers |
| icr_out | output | DATA_W | Initiator command byte, to the bus drivers |
| tcr_out | output | DATA_W | Target command byte with the last-byte flag |
| dma_mode_out | output | 2 | Transfer direction: 0 idle, 1 send, 2 initiator receive |
| dma_active_out | output | 1 | Transfer enabled and direction non-idle |
| irq_out | output | 1 | Interrupt flag |

## Verification
The status word is tried with bus patterns that hold the phase lines equal to the programmed phase while REQ, BSY and ACK are toggled. This separates the request-for-data gating by the DMA bit from the busy-loss gating by the monitor bit, and from the phase comparison. The data read is tried with drive-data both set and clear, so that the latch and the live bus are told apart. Flag handling is tried with a set pulse and a clear in separate cycles and in the same cycle, which shows which of the two has priority. Start strobes are tried with the DMA bit set and clear, which separates the direction from transfer-active.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

  localparam int ADDR_W = 3;

  // Host offsets: fixed because software decodes them
  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_ICMD  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_TCMD  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_BUSST = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_TRCV  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_IRCV  = 3'd7;

  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_SEND  = 2'd1,
    XFER_IRECV = 2'd2
  } xfer_mode_e;

  // Initiator command / mode bits
  localparam int ICMD_DRIVE_BIT  = 0;
  localparam int MODE_XFER_BIT   = 1;
  localparam int MODE_BSYMON_BIT = 2;
  localparam int MODE_EOPIRQ_BIT = 3;

  // Sampled control lines
  localparam int CTL_BSY = 6;
  localparam int CTL_REQ = 5;
  localparam int CTL_MSG = 4;
  localparam int CTL_CD  = 3;
  localparam int CTL_IO  = 2;

  // Composite status word
  localparam int ST_ACK    = 0;
  localparam int ST_BSYERR = 2;
  localparam int ST_PHASE  = 3;
  localparam int ST_IRQ    = 4;
  localparam int ST_PAR    = 5;
  localparam int ST_DRQ    = 6;
  localparam int ST_EOD    = 7;

endpackage

// File: rtl/scsi_rst_sync.sv
module scsi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/scsi_reg_bank.sv
module scsi_reg_bank
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TCMD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lbs_set,
  output logic [DATA_W-1:0] odr_q,
  output logic [DATA_W-1:0] icr_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [TCMD_W-1:0] tcmd_q,
  output logic              lbs_q,
  output xfer_mode_e        xm_q,
  output logic              mode_clr
);
  logic       ld_odr, ld_icr, ld_mode, ld_tcmd, ld_xm, ld_lbs;
  xfer_mode_e xm_d;
  logic       lbs_d;

  always_comb begin
    ld_odr   = wr_en && (addr == OFS_DATA);
    ld_icr   = wr_en && (addr == OFS_ICMD);
    ld_mode  = wr_en && (addr == OFS_MODE);
    ld_tcmd  = wr_en && (addr == OFS_TCMD);
    mode_clr = ld_mode && !wdata[MODE_XFER_BIT];

    xm_d  = xm_q;
    ld_xm = 1'b0;
    if (mode_clr) begin
      xm_d  = XFER_IDLE;
      ld_xm = 1'b1;
    end else if (wr_en && (addr == OFS_STAT)) begin
      xm_d  = XFER_SEND;
      ld_xm = 1'b1;
    end else if (wr_en && (addr == OFS_IRCV)) begin
      xm_d  = XFER_IRECV;
      ld_xm = 1'b1;
    end

    lbs_d  = mode_clr ? 1'b0 : 1'b1;
    ld_lbs = mode_clr || lbs_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q  <= '0;
      icr_q  <= '0;
      mode_q <= '0;
      tcmd_q <= '0;
      lbs_q  <= 1'b0;
      xm_q   <= XFER_IDLE;
    end else begin
      if (ld_odr)  odr_q  <= wdata;
      if (ld_icr)  icr_q  <= wdata;
      if (ld_mode) mode_q <= wdata;
      if (ld_tcmd) tcmd_q <= wdata[TCMD_W-1:0];
      if (ld_lbs)  lbs_q  <= lbs_d;
      if (ld_xm)   xm_q   <= xm_d;
    end
  end
endmodule

// File: rtl/scsi_flag_ctl.sv
module scsi_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic eop_set,
  input  logic par_set,
  input  logic rd_clr,
  input  logic mode_clr,
  input  logic eop_irq_en,
  output logic eod_q,
  output logic irq_q,
  output logic par_q
);
  logic eod_d, irq_d, par_d;
  logic ld_eod, ld_irq, ld_par;

  always_comb begin
    ld_eod = mode_clr || eop_set;
    eod_d  = !mode_clr;
    ld_irq = rd_clr || (eop_set && eop_irq_en);
    irq_d  = eop_set && eop_irq_en;
    ld_par = rd_clr || par_set;
    par_d  = par_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eod_q <= 1'b0;
      irq_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      if (ld_eod) eod_q <= eod_d;
      if (ld_irq) irq_q <= irq_d;
      if (ld_par) par_q <= par_d;
    end
  end
endmodule

// File: rtl/scsi_read_mux.sv
module scsi_read_mux
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] odr,
  input  logic [DATA_W-1:0] icr,
  input  logic [DATA_W-1:0] mode,
  input  logic [DATA_W-1:0] tcr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] bus_ctl,
  input  logic              bus_ack,
  input  logic              eod,
  input  logic              irq,
  input  logic              par,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] stat_word;
  logic              phase_ok;

  always_comb begin
    phase_ok  = (tcr[2:0] == {bus_ctl[CTL_MSG], bus_ctl[CTL_CD], bus_ctl[CTL_IO]});
    stat_word = '0;
    stat_word[ST_ACK]    = bus_ack;
    stat_word[ST_BSYERR] = !bus_ctl[CTL_BSY] && mode[MODE_BSYMON_BIT];
    stat_word[ST_PHASE]  = phase_ok;
    stat_word[ST_IRQ]    = irq;
    stat_word[ST_PAR]    = par;
    stat_word[ST_DRQ]    = bus_ctl[CTL_REQ] && mode[MODE_XFER_BIT];
    stat_word[ST_EOD]    = eod;
  end

  always_comb begin
    case (addr)
      OFS_DATA:  rdata = icr[ICMD_DRIVE_BIT] ? odr : bus_data;
      OFS_ICMD:  rdata = icr;
      OFS_MODE:  rdata = mode;
      OFS_TCMD:  rdata = tcr;
      OFS_BUSST: rdata = bus_ctl;
      OFS_STAT:  rdata = stat_word;
      default:   rdata = '1;
    endcase
  end
endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TCMD_W    = 4,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic [DATA_W-1:0] bus_ctl_in,
  input  logic              bus_ack_in,
  input  logic              par_err_in,
  input  logic              eop_in,
  input  logic              lbs_in,
  output logic [DATA_W-1:0] odr_out,
  output logic [DATA_W-1:0] icr_out,
  output logic [DATA_W-1:0] tcr_out,
  output logic [1:0]        dma_mode_out,
  output logic              dma_active_out,
  output logic              irq_out
);
  localparam int TPAD_W = DATA_W - 1 - TCMD_W;

  logic              rst_sync_n;
  logic [DATA_W-1:0] odr_q, icr_q, mode_q;
  logic [TCMD_W-1:0] tcmd_q;
  logic              lbs_q, mode_clr;
  xfer_mode_e        xm_q;
  logic              eod_q, irq_q, par_q;
  logic              rd_clr;
  logic [DATA_W-1:0] tcr_w;

  scsi_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  scsi_reg_bank #(.DATA_W(DATA_W), .TCMD_W(TCMD_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(host_wr), .addr(host_addr),
    .wdata(host_wdata), .lbs_set(lbs_in), .odr_q(odr_q), .icr_q(icr_q),
    .mode_q(mode_q), .tcmd_q(tcmd_q), .lbs_q(lbs_q), .xm_q(xm_q),
    .mode_clr(mode_clr)
  );

  assign rd_clr = host_rd && (host_addr == OFS_IRCV);

  scsi_flag_ctl u_flags (
    .clk(clk), .rst_n(rst_sync_n), .eop_set(eop_in), .par_set(par_err_in),
    .rd_clr(rd_clr), .mode_clr(mode_clr),
    .eop_irq_en(mode_q[MODE_EOPIRQ_BIT]),
    .eod_q(eod_q), .irq_q(irq_q), .par_q(par_q)
  );

  assign tcr_w = {lbs_q, {TPAD_W{1'b0}}, tcmd_q};

  scsi_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .addr(host_addr), .odr(odr_q), .icr(icr_q), .mode(mode_q), .tcr(tcr_w),
    .bus_data(bus_data_in), .bus_ctl(bus_ctl_in), .bus_ack(bus_ack_in),
    .eod(eod_q), .irq(irq_q), .par(par_q), .rdata(host_rdata)
  );

  assign odr_out        = odr_q;
  assign icr_out        = icr_q;
  assign tcr_out        = tcr_w;
  assign dma_mode_out   = xm_q;
  assign dma_active_out = mode_q[MODE_XFER_BIT] && (xm_q != XFER_IDLE);
  assign irq_out        = irq_q;
endmodule

// File: rtl/scsi_host_regs_chk.sv
module scsi_host_regs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [2:0]        host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              eop_in,
  input logic              par_err_in,
  input logic [1:0]        dma_mode_out,
  input logic              dma_active_out,
  input logic              irq_out,
  input logic [DATA_W-1:0] tcr_out,
  input logic              eod_q
);
  logic mode_stop;
  assign mode_stop = host_wr && (host_addr == 3'd2) && !host_wdata[1];

  a_r7_send_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr && (host_addr == 3'd5) |=> dma_mode_out == 2'd1);

  a_r7_irecv_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_wr && (host_addr == 3'd7) |=> dma_mode_out == 2'd2);

  a_r8_mode_stop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_stop |=> (dma_mode_out == 2'd0) && !dma_active_out
                  && !tcr_out[DATA_W-1] && !eod_q);

  a_r9_read7_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_rd && (host_addr == 3'd7) && !eop_in && !par_err_in |=> !irq_out);

  a_r10_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_addr == 3'd6) || (host_addr == 3'd7) |-> host_rdata == {DATA_W{1'b1}});

  a_r11_eop_latch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eop_in && !mode_stop |=> eod_q);
endmodule

bind scsi_host_regs scsi_host_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .host_addr(host_addr),
  .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .eop_in(eop_in), .par_err_in(par_err_in),
  .dma_mode_out(dma_mode_out), .dma_active_out(dma_active_out),
  .irq_out(irq_out), .tcr_out(tcr_out), .eod_q(eod_q)
);

// File: tb/scsi_host_regs_bench.sv
`timescale 1ns/1ps
module scsi_host_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] host_addr;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic [7:0] bus_data_in, bus_ctl_in;
  logic       bus_ack_in, par_err_in, eop_in, lbs_in;
  logic [7:0] odr_out, icr_out, tcr_out;
  logic [1:0] dma_mode_out;
  logic       dma_active_out, irq_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  scsi_host_regs u_scsi_host_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_data_in(bus_data_in), .bus_ctl_in(bus_ctl_in), .bus_ack_in(bus_ack_in),
    .par_err_in(par_err_in), .eop_in(eop_in), .lbs_in(lbs_in),
    .odr_out(odr_out), .icr_out(icr_out), .tcr_out(tcr_out),
    .dma_mode_out(dma_mode_out), .dma_active_out(dma_active_out),
    .irq_out(irq_out)
  );

  // Behavioural reference model
  logic [7:0] m_odr, m_icr, m_mode;
  logic [3:0] m_tcmd;
  logic       m_lbs, m_eod, m_irq, m_par;
  logic [1:0] m_dir;
  int         rel_cnt;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    logic [7:0] s;
    case (a)
      3'd0: return m_icr[0] ? m_odr : bus_data_in;
      3'd1: return m_icr;
      3'd2: return m_mode;
      3'd3: return {m_lbs, 3'b000, m_tcmd};
      3'd4: return bus_ctl_in;
      3'd5: begin
        s = 8'h00;
        s[0] = bus_ack_in;
        s[2] = !bus_ctl_in[6] && m_mode[2];
        s[3] = (m_tcmd[2:0] == {bus_ctl_in[4], bus_ctl_in[3], bus_ctl_in[2]});
        s[4] = m_irq;
        s[5] = m_par;
        s[6] = bus_ctl_in[5] && m_mode[1];
        s[7] = m_eod;
        return s;
      end
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_odr = 0; m_icr = 0; m_mode = 0; m_tcmd = 0;
      m_lbs = 0; m_eod = 0; m_irq = 0; m_par = 0; m_dir = 0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt = rel_cnt + 1;
    end else begin
      bit clr7, stop;
      logic n_irq, n_par, n_eod, n_lbs;
      clr7  = host_rd && host_addr == 3'd7;
      stop  = host_wr && host_addr == 3'd2 && !host_wdata[1];
      n_irq = (clr7 ? 1'b0 : m_irq) | (eop_in & m_mode[3]);
      n_par = (clr7 ? 1'b0 : m_par) | par_err_in;
      n_eod = stop ? 1'b0 : (m_eod | eop_in);
      n_lbs = stop ? 1'b0 : (m_lbs | lbs_in);
      if (host_wr) begin
        case (host_addr)
          3'd0: m_odr = host_wdata;
          3'd1: m_icr = host_wdata;
          3'd2: begin m_mode = host_wdata; if (stop) m_dir = 0; end
          3'd3: m_tcmd = host_wdata[3:0];
          3'd5: m_dir = 1;
          3'd7: m_dir = 2;
          default: ;
        endcase
      end
      m_irq = n_irq; m_par = n_par; m_eod = n_eod; m_lbs = n_lbs;
    end
  end

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (host_rdata !== m_read(host_addr) || dma_mode_out !== m_dir ||
          dma_active_out !== (m_mode[1] && m_dir != 0) || irq_out !== m_irq ||
          odr_out !== m_odr || icr_out !== m_icr ||
          tcr_out !== {m_lbs, 3'b000, m_tcmd}) begin
        errors++;
        $display("FAIL model R2 R3 R5 R6 R7 R11: rdata=%h/%h dir=%0d/%0d act=%b irq=%b/%b tcr=%h",
                 host_rdata, m_read(host_addr), dma_mode_out, m_dir,
                 dma_active_out, irq_out, m_irq, tcr_out);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_wr = 0; host_rd = 0; host_addr = 3'd1; host_wdata = 0;
    par_err_in = 0; eop_in = 0; lbs_in = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    host_addr = a; host_wdata = d; host_wr = 1;
    @(posedge clk); #2;
    idle_inputs();
  endtask

  // Read strobe; value sampled at the negedge of the strobe cycle
  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #2;
    host_addr = a; host_rd = 1;
    @(negedge clk);
    v = host_rdata;
    @(posedge clk); #2;
    idle_inputs();
  endtask

  // Address only, no strobe, sampled at the following negedge
  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #2;
    host_addr = a;
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 0;
    idle_inputs();
    bus_data_in = 8'hA3; bus_ctl_in = 8'h5C; bus_ack_in = 1;
    do_reset();

    // R1 reset state
    peek(3'd1, v); check("R1 icr", v, 8'h00);
    peek(3'd2, v); check("R1 mode", v, 8'h00);
    peek(3'd3, v); check("R1 tcr", v, 8'h00);
    check("R1 dir", {6'd0, dma_mode_out}, 8'h00);
    check("R1 irq", {7'd0, irq_out}, 8'h00);

    // R2 data read selection
    wr(3'd0, 8'h55);
    peek(3'd0, v); check("R2 live bus", v, 8'hA3);
    wr(3'd1, 8'h01);
    peek(3'd0, v); check("R2 latched byte", v, 8'h55);

    // R3 readback
    wr(3'd2, 8'h0E);
    wr(3'd3, 8'h8F);
    peek(3'd3, v); check("R3 tcr masked", v, 8'h0F);
    peek(3'd2, v); check("R3 mode", v, 8'h0E);
    peek(3'd1, v); check("R3 icr", v, 8'h01);

    // R4 bus control byte
    peek(3'd4, v); check("R4 busst", v, 8'h5C);

    // R5 phase match and ACK, no REQ
    peek(3'd5, v); check("R5 match ack", v, 8'h09);
    bus_ctl_in = 8'h7C;
    peek(3'd5, v); check("R5 drq", v, 8'h49);
    // R6 busy loss with monitor on
    bus_ctl_in = 8'h3C;
    peek(3'd5, v); check("R6 bsy err", v, 8'h4D);
    bus_ctl_in = 8'h58;  // I/O low: phase mismatch
    peek(3'd5, v); check("R5 mismatch", v, 8'h01);
    bus_ctl_in = 8'h5C; bus_ack_in = 0;
    peek(3'd5, v); check("R5 base", v, 8'h08);

    // R7 start strobes
    wr(3'd5, 8'h00);
    @(negedge clk);
    check("R7 send dir", {6'd0, dma_mode_out}, 8'h01);
    check("R7 active", {7'd0, dma_active_out}, 8'h01);
    wr(3'd7, 8'h00);
    @(negedge clk);
    check("R7 irecv dir", {6'd0, dma_mode_out}, 8'h02);

    // R11 flags
    @(posedge clk); #2 lbs_in = 1; @(posedge clk); #2 idle_inputs();
    peek(3'd3, v); check("R11 lbs", v, 8'h8F);
    @(posedge clk); #2 eop_in = 1; @(posedge clk); #2 idle_inputs();
    peek(3'd5, v); check("R11 eod irq", v, 8'h98);
    check("R11 irq pin", {7'd0, irq_out}, 8'h01);

    // R9 clear on read of offset 7
    @(posedge clk); #2 par_err_in = 1; @(posedge clk); #2 idle_inputs();
    peek(3'd5, v); check("R6 parity", v, 8'hB8);
    rd(3'd7, v); check("R10 read7", v, 8'hFF);
    peek(3'd5, v); check("R9 cleared", v, 8'h88);
    check("R9 irq pin", {7'd0, irq_out}, 8'h00);
    @(posedge clk); #2 host_addr = 3'd7; host_rd = 1; eop_in = 1;
    @(posedge clk); #2 idle_inputs();
    @(negedge clk); check("R9 set wins", {7'd0, irq_out}, 8'h01);

    // R8 mode write stops transfer
    @(posedge clk); #2 host_addr = 3'd2; host_wdata = 8'h08; host_wr = 1; eop_in = 1; lbs_in = 1;
    @(posedge clk); #2 idle_inputs();
    @(negedge clk);
    check("R8 dir idle", {6'd0, dma_mode_out}, 8'h00);
    check("R8 inactive", {7'd0, dma_active_out}, 8'h00);
    peek(3'd3, v); check("R8 lbs cleared", v, 8'h0F);
    peek(3'd5, v); check("R8 eod cleared", v, 8'h18);

    // R12 ignored writes
    wr(3'd4, 8'hFF);
    wr(3'd6, 8'hFF);
    peek(3'd0, v); check("R12 odr", v, 8'h55);
    peek(3'd1, v); check("R12 icr", v, 8'h01);
    peek(3'd2, v); check("R12 mode", v, 8'h08);
    peek(3'd3, v); check("R12 tcr", v, 8'h0F);
    check("R12 dir", {6'd0, dma_mode_out}, 8'h00);
    peek(3'd6, v); check("R10 read6", v, 8'hFF);

    // R7 direction without DMA enable
    wr(3'd5, 8'h00);
    @(negedge clk);
    check("R7 dir no en", {6'd0, dma_mode_out}, 8'h01);
    check("R7 inactive no en", {7'd0, dma_active_out}, 8'h00);
    wr(3'd2, 8'h0A);
    @(negedge clk);
    check("R7 active after en", {7'd0, dma_active_out}, 8'h01);

    // R1 reset mid-run
    do_reset();
    peek(3'd0, v); check("R1 data after reset", v, 8'hA3);
    peek(3'd2, v); check("R1 mode after reset", v, 8'h00);
    check("R1 active after reset", {7'd0, dma_active_out}, 8'h00);

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule